// File: doc/BRIEF.md
# Iterative Phase Jump Compensator

This block sits in one clock input channel, right after the phase comparator. Once per second it takes a signed phase-difference sample. It subtracts the offset it has built up so far, then compares the corrected value with a held reference phase. If the corrected phase has moved from the reference by more than a programmed threshold, the block raises a jump flag. It does not remove the whole jump in one subtraction. Starting with the next sample, it moves its accumulated offset by one threshold per sample, in the direction of the jump.

After each step the block spends one clock verifying. It compares the remaining residual with the threshold. If the residual is still outside the threshold, the next sample brings another step. Once the residual is inside the threshold, the block emits a one-clock done pulse, drops the flag, and takes the latest corrected phase as its new reference.

Samples enter and leave through valid/ready handshakes. The output holds one corrected sample. While that sample is waiting with `out_ready` low, `in_ready` stays low. `in_ready` is also low during every verify clock. A stalled sample is never lost or changed. Phase arithmetic wraps in two's complement at `W` bits.

Top module: `phase_jump_comp`

## Requirements
- R1: During and right after reset, `out_valid`, `jump_flag` and `jump_done` are 0, `offset` is 0, and `in_ready` is 1.
- R2: Each accepted sample gives exactly one output sample one clock later, equal to the input minus the offset in force for that sample.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_phase` holds its value and `in_ready` is 0. `out_valid` falls on the first clock after `out_ready` returns high, unless a new sample is loaded in that clock.
- R4: The first sample after reset only sets the reference. It never raises the flag.
- R5: A later sample whose corrected phase differs from the reference by strictly more than `thr` raises `jump_flag` together with that sample's output. That output and `offset` are not yet corrected.
- R6: On the next accepted sample, `offset` moves by exactly `thr`. It rises by `thr` for a positive jump and falls by `thr` for a negative one. The output is that sample minus the new offset.
- R7: After a correcting sample, one clock later the residual (corrected output minus reference) is compared with `thr`. If its magnitude exceeds `thr`, another step follows on the next sample, with the sign of that residual, and `jump_flag` stays 1.
- R8: When the residual magnitude is at most `thr`, `jump_done` is 1 for exactly one clock and `jump_flag` falls in that same clock. The reference then becomes the last corrected output.
- R9: A `thr` of 0 disables detection. Samples pass with the current offset and no flag.
- R10: A change exactly equal to `thr` is not a jump.
- R11: `in_ready` is 0 in the clock that follows each correcting sample (the verify clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts a sample this clock |
| in_phase | input | W | Signed phase-difference sample |
| thr | input | W-1 | Jump threshold and correction step size (unsigned) |
| out_valid | output | 1 | Corrected sample valid |
| out_ready | input | 1 | Consumer takes the corrected sample |
| out_phase | output | W | Corrected phase (sample minus offset) |
| jump_flag | output | 1 | Jump detected and correction in progress |
| jump_done | output | 1 | One-clock pulse when the residual settles |
| offset | output | W | Accumulated correction offset (signed) |

## Verification
The verify clock of the final correction step can coincide with the consumer holding the output stalled. In that clock the done pulse, the fall of the flag and the reference update all happen while a corrected sample is parked in the output register. The bench provokes this by lowering `out_ready` just before a correcting sample is sent. It then expects the done pulse on the clock after acceptance and an unchanged `out_phase` for several clocks. It also expects `in_ready` to stay low until the consumer drains the output. Random runs mix jumps of many sizes with changes of threshold while the block is idle, and check each output against a sample-level model of the requirements.

// File: rtl/phj_pkg.sv
package phj_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CORRECT = 2'd1,
    ST_VERIFY  = 2'd2
  } phj_state_e;
endpackage

// File: rtl/phj_mag_cmp.sv
// Signed magnitude versus unsigned threshold; zero threshold never exceeds.
module phj_mag_cmp #(
  parameter int W = 24
) (
  input  logic signed [W-1:0] val,
  input  logic [W-2:0]        thr,
  output logic                over
);
  localparam int MW = W + 1;
  logic [MW-1:0] ext;
  logic [MW-1:0] mag;

  always_comb begin
    ext  = {val[W-1], val};
    mag  = val[W-1] ? (~ext + 1'b1) : ext;
    over = (thr != '0) && (mag > {2'b00, thr});
  end
endmodule

// File: rtl/phj_arith.sv
// Applies an optional threshold step to the offset, corrects the sample,
// and forms the difference to the reference.
module phj_arith #(
  parameter int W = 24
) (
  input  logic signed [W-1:0] sample,
  input  logic signed [W-1:0] offset_cur,
  input  logic signed [W-1:0] ref_ph,
  input  logic [W-2:0]        thr,
  input  logic                step_en,
  input  logic                step_neg,
  output logic signed [W-1:0] offset_nx,
  output logic signed [W-1:0] corr,
  output logic signed [W-1:0] diff
);
  logic signed [W-1:0] step;

  always_comb begin
    step = $signed({1'b0, thr});
    if (!step_en)
      offset_nx = offset_cur;
    else if (step_neg)
      offset_nx = offset_cur - step;
    else
      offset_nx = offset_cur + step;
    corr = sample - offset_nx;
    diff = corr - ref_ph;
  end
endmodule

// File: rtl/phj_ctrl.sv
module phj_ctrl
  import phj_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_fire,
  input  logic [W-2:0]        thr,
  input  logic                over_now,
  input  logic                over_res,
  input  logic signed [W-1:0] diff,
  input  logic signed [W-1:0] corr,
  input  logic signed [W-1:0] offset_nx,
  output phj_state_e          state_q,
  output logic signed [W-1:0] offset_q,
  output logic signed [W-1:0] ref_q,
  output logic signed [W-1:0] residual_q,
  output logic                step_neg_q,
  output logic                flag_q,
  output logic                done_q
);
  logic                have_ref_q;
  logic signed [W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      offset_q   <= '0;
      ref_q      <= '0;
      residual_q <= '0;
      last_q     <= '0;
      step_neg_q <= 1'b0;
      have_ref_q <= 1'b0;
      flag_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (in_fire) begin
          if (!have_ref_q) begin
            ref_q      <= corr;
            have_ref_q <= 1'b1;
          end else if (over_now) begin
            state_q    <= ST_CORRECT;
            flag_q     <= 1'b1;
            step_neg_q <= diff[W-1];
          end else begin
            ref_q <= corr;
          end
        end
        ST_CORRECT: if (in_fire) begin
          offset_q   <= offset_nx;
          residual_q <= diff;
          last_q     <= corr;
          state_q    <= ST_VERIFY;
        end
        ST_VERIFY: begin
          if (!over_res) begin
            done_q  <= 1'b1;
            flag_q  <= 1'b0;
            ref_q   <= last_q;
            state_q <= ST_IDLE;
          end else begin
            step_neg_q <= residual_q[W-1];
            state_q    <= ST_CORRECT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: done is a single-clock pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: flag falls in the clock where done rises
  a_r8_done_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $fell(flag_q));
  // R6: offset only ever moves by one threshold
  a_r6_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset_q) |->
      ((offset_q - $past(offset_q)) == $signed({1'b0, $past(thr)})) ||
      (($past(offset_q) - offset_q) == $signed({1'b0, $past(thr)})));
  // R7: while correcting, flag is held
  a_r7_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CORRECT) |-> flag_q);
endmodule

// File: rtl/phj_out_stage.sv
module phj_out_stage #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic signed [W-1:0] data_in,
  input  logic                out_ready,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= data_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R3: stalled output stays valid and unchanged
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/phase_jump_comp.sv
module phase_jump_comp
  import phj_pkg::*;
#(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_phase,
  input  logic [W-2:0]        thr,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_phase,
  output logic                jump_flag,
  output logic                jump_done,
  output logic signed [W-1:0] offset
);
  phj_state_e          state_q;
  logic signed [W-1:0] offset_q, ref_q, residual_q;
  logic signed [W-1:0] offset_nx, corr, diff;
  logic                step_neg_q, over_now, over_res, in_fire;

  assign in_ready = (state_q != ST_VERIFY) && (!out_valid || out_ready);
  assign in_fire  = in_valid && in_ready;

  phj_arith #(.W(W)) u_arith (
    .sample(in_phase), .offset_cur(offset_q), .ref_ph(ref_q), .thr(thr),
    .step_en(state_q == ST_CORRECT), .step_neg(step_neg_q),
    .offset_nx(offset_nx), .corr(corr), .diff(diff));

  phj_mag_cmp #(.W(W)) u_cmp_now (.val(diff), .thr(thr), .over(over_now));
  phj_mag_cmp #(.W(W)) u_cmp_res (.val(residual_q), .thr(thr), .over(over_res));

  phj_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .thr(thr),
    .over_now(over_now), .over_res(over_res), .diff(diff), .corr(corr),
    .offset_nx(offset_nx), .state_q(state_q), .offset_q(offset_q),
    .ref_q(ref_q), .residual_q(residual_q), .step_neg_q(step_neg_q),
    .flag_q(jump_flag), .done_q(jump_done));

  phj_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(in_fire), .data_in(corr),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_phase));

  assign offset = offset_q;

  // R5: the flag only rises together with a fresh output sample
  a_r5_flag_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jump_flag) |-> out_valid);
  // R11: no sample accepted in the clock after a correcting sample
  a_r11_verify_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && state_q == ST_CORRECT) |=> !in_ready);
endmodule

// File: tb/phase_jump_comp_bench.sv
module phase_jump_comp_bench;
  localparam int W = 24;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic signed [W-1:0] in_phase = '0;
  logic [W-2:0]        thr = '0;
  logic                out_valid;
  logic                out_ready = 1'b1;
  logic signed [W-1:0] out_phase;
  logic                jump_flag, jump_done;
  logic signed [W-1:0] offset;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // sample-level model state
  logic signed [W-1:0] m_off, m_ref;
  bit m_have, m_corr, m_neg;

  always #4 clk = ~clk;

  phase_jump_comp #(.W(W)) u_phase_jump_comp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .thr(thr), .out_valid(out_valid),
    .out_ready(out_ready), .out_phase(out_phase), .jump_flag(jump_flag),
    .jump_done(jump_done), .offset(offset));

  function automatic bit exceeds(logic signed [W-1:0] v, logic [W-2:0] t);
    int a;
    a = int'(v);
    if (a < 0) a = -a;
    return (t != 0) && (a > int'(t));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic signed [W-1:0] x);
    logic signed [W-1:0] e_out, r;
    bit e_flag, was_corr, e_done;
    was_corr = 1'b0;
    e_done = 1'b0;
    if (!m_have) begin
      e_out = x - m_off; m_ref = e_out; m_have = 1'b1; e_flag = 1'b0;
    end else if (!m_corr) begin
      e_out = x - m_off;
      if (exceeds(e_out - m_ref, thr)) begin
        m_corr = 1'b1; m_neg = (e_out - m_ref) < 0; e_flag = 1'b1;
      end else begin
        m_ref = e_out; e_flag = 1'b0;
      end
    end else begin
      was_corr = 1'b1;
      m_off = m_neg ? m_off - $signed({1'b0, thr}) : m_off + $signed({1'b0, thr});
      e_out = x - m_off;
      e_flag = 1'b1;
      r = e_out - m_ref;
      if (!exceeds(r, thr)) begin
        e_done = 1'b1; m_corr = 1'b0; m_ref = e_out;
      end else begin
        m_neg = r < 0;
      end
    end
    @(negedge clk);
    in_valid = 1'b1; in_phase = x;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 out_valid", int'(out_valid), 1);
    chk("R2 out_phase", int'(out_phase), int'(e_out));
    chk("R5 jump_flag", int'(jump_flag), int'(e_flag));
    chk("R6 offset", int'(offset), int'(m_off));
    if (was_corr) begin
      chk("R11 in_ready in verify clock", int'(in_ready), 0);
      @(negedge clk);
      chk("R8 jump_done", int'(jump_done), int'(e_done));
      chk("R7 flag after verify", int'(jump_flag), e_done ? 0 : 1);
    end else begin
      chk("R8 no done", int'(jump_done), 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic signed [W-1:0] held, x;
    int p;
    void'($urandom(32'd4711));
    m_off = '0; m_ref = '0; m_have = 0; m_corr = 0; m_neg = 0;
    thr = 23'd10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 jump_flag", int'(jump_flag), 0);
    chk("R1 jump_done", int'(jump_done), 0);
    chk("R1 offset", int'(offset), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 offset after release", int'(offset), 0);

    send(24'sd100);   // R4 first sample sets reference
    chk("R4 no flag on first sample", int'(jump_flag), 0);
    send(24'sd105);   // R2 small move
    send(24'sd115);   // R10 change equal to threshold
    chk("R10 equal change is no jump", int'(jump_flag), 0);
    send(24'sd145);   // R5 +30 jump
    send(24'sd145);   // R6, R7 first step, residual 20
    send(24'sd145);   // R8 second step, residual 10 -> done
    send(24'sd125);   // negative jump of -20
    send(24'sd125);   // R6 negative step, done
    chk("R6 offset after negative step", int'(offset), 10);

    thr = '0;         // R9 detection disabled
    send(24'sd500);
    chk("R9 no flag with zero threshold", int'(jump_flag), 0);
    thr = 23'd10;
    send(24'sd500);
    send(24'sd540);   // jump +40 -> steps until inside threshold
    send(24'sd540);
    send(24'sd540);
    // R3 / R11: final correcting step with a stalled consumer
    @(negedge clk);
    out_ready = 1'b0;
    send(24'sd540);
    held = out_phase;
    repeat (3) begin
      @(negedge clk);
      chk("R3 out_valid held", int'(out_valid), 1);
      chk("R3 out_phase stable", int'(out_phase), int'(held));
      chk("R3 in_ready low while stalled", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R3 out_valid drains", int'(out_valid), 0);

    // constrained random walk with occasional jumps
    p = 1000;
    for (int i = 0; i < 300; i++) begin
      if (!m_corr && ($urandom % 10 == 0)) thr = 23'($urandom_range(60, 1));
      if ($urandom % 7 == 0)
        p = p + int'($urandom_range(400, 0)) - 200;
      else
        p = p + int'($urandom_range(8, 0)) - 4;
      x = W'(p);
      send(x);
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule